// File: doc/BRIEF.md
# Framebuffer 24-bit Pixel Unpacker

This block sits between the word fetcher of a display controller and the pixel pipeline of a TFT panel. It accepts 32-bit framebuffer words on a valid/ready input and produces 24-bit pixels on a valid/ready output. Two storage layouts are understood. In the dense layout, four pixels share three consecutive words, so pixel bytes straddle word boundaries. In the sparse layout, every word carries one pixel in its low three bytes and the top byte is unused.

The direct 24-bit path is enabled only when both the panel-type input (`tftEnable`) and the deep-colour input (`deep24Enable`) are high. In every other case the words are meant for palette lookup downstream. The block then emits no pixels and forwards the words unchanged on a bypass output. A single-cycle `frameStart` pulse returns the word phase to its start and discards any leftover bytes. Mode inputs are only guaranteed to take effect cleanly from a frame start onward.

Top module: `pix24_unpacker`

## Requirements
- R1: `pixValid` is 0 whenever `tftEnable` and `deep24Enable` are not both 1.
- R2: When the direct path is off and `frameStart` is 0, `bypassValid` equals `inValid`, `bypassData` equals `inData` and `inReady` equals `bypassReady`, all in the same cycle.
- R3: In the dense layout (`rawFormat`=0), the first word of a group emits pixel 0 = word0[23:0] in the same cycle in which the word is presented, with `inReady` equal to `pixReady`.
- R4: The second word of a dense group emits pixel 1 = {word1[15:0], word0[31:24]}.
- R5: The third word of a dense group emits pixel 2 = {word2[7:0], word1[31:16]}.
- R6: After the third dense word is accepted, the next cycles present pixel 3 = word2[31:8] with `pixValid`=1 and `inReady`=0 until `pixReady` is 1. The following word then starts a new group.
- R7: In the sparse layout (`rawFormat`=1), every word emits one pixel equal to word[23:0]. Bits [31:24] have no effect, and the phase never leaves the group start.
- R8: While `pixReady` is 0, no word is consumed (`inReady`=0) and a held pixel 3 stays valid with unchanged data.
- R9: In a cycle where `frameStart` is 1, `inReady`, `pixValid` and `bypassValid` are 0. The next word is treated as the first word of a group, and leftover bytes are discarded.
- R10: After reset, the mode inputs are taken as 0 (bypass), and the first direct-mode word is treated as the first word of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start-of-frame pulse; clears phase and leftover bytes |
| tftEnable | input | 1 | Panel is active-matrix |
| deep24Enable | input | 1 | Direct 24-bit colour selected |
| rawFormat | input | 1 | 1 = one pixel per word, 0 = four pixels per three words |
| inValid | input | 1 | Framebuffer word valid |
| inData | input | 32 | Framebuffer word |
| inReady | output | 1 | Word accepted when high together with inValid |
| pixValid | output | 1 | 24-bit pixel valid |
| pixData | output | 24 | 24-bit pixel |
| pixReady | input | 1 | Downstream takes the pixel |
| bypassValid | output | 1 | Word forwarded for palette lookup |
| bypassData | output | 32 | Forwarded word |
| bypassReady | input | 1 | Palette path takes the word |

## Verification
The hardest state to reach is a pending pixel 3 held under backpressure. It needs three accepted dense words followed by a stalled sink, and the stall must not bring in a fourth word. The stimulus completes a full group and then holds `pixReady` low for several cycles, checking stable data with `inReady` low. A second case places `frameStart` in the middle of a group to prove that the leftover bytes are dropped, since the next word must come out exactly as a group start.

// File: rtl/pix24_pkg.sv
package pix24_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = WORD_W / 4;
  localparam int PIX_W  = 3 * BYTE_W;

  typedef enum logic [1:0] {
    PH_W0   = 2'd0,
    PH_W1   = 2'd1,
    PH_W2   = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  typedef struct packed {
    phase_e sel;      // current group position
    logic   capture;  // store leftover bytes of the presented word
    logic   unpacked; // one pixel per word
  } dpCtl_t;
endpackage

// File: rtl/pix24_datapath.sv
module pix24_datapath
  import pix24_pkg::*;
#(
  parameter int WordW = WORD_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [WordW-1:0]        inData,
  output logic [3*(WordW/4)-1:0]  pixData
);
  localparam int ByteW = WordW / 4;
  localparam int PixW  = 3 * ByteW;

  logic [PixW-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctl.capture) begin
      unique case (ctl.sel)
        PH_W0:   holdReg <= {{(2*ByteW){1'b0}}, inData[WordW-1 -: ByteW]};
        PH_W1:   holdReg <= {{ByteW{1'b0}}, inData[WordW-1 -: 2*ByteW]};
        PH_W2:   holdReg <= inData[WordW-1 -: PixW];
        default: holdReg <= holdReg;
      endcase
    end
  end

  always_comb begin
    if (ctl.sel == PH_HOLD) begin
      pixData = holdReg;
    end else if (ctl.unpacked) begin
      pixData = inData[PixW-1:0];
    end else begin
      unique case (ctl.sel)
        PH_W1:   pixData = {inData[2*ByteW-1:0], holdReg[ByteW-1:0]};
        PH_W2:   pixData = {inData[ByteW-1:0], holdReg[2*ByteW-1:0]};
        default: pixData = inData[PixW-1:0];
      endcase
    end
  end

  // R6
  held_pixel_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == PH_HOLD && !ctl.capture) |=> $stable(holdReg));
endmodule

// File: rtl/pix24_ctrl.sv
module pix24_ctrl
  import pix24_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameStart,
  input  logic   tftEnable,
  input  logic   deep24Enable,
  input  logic   rawFormat,
  input  logic   inValid,
  input  logic   pixReady,
  input  logic   bypassReady,
  output logic   inReady,
  output logic   pixValid,
  output logic   bypassValid,
  output dpCtl_t ctl
);
  phase_e phase, phaseNext;
  logic   direct;
  logic   accept;

  assign direct = tftEnable && deep24Enable;
  assign accept = inValid && inReady;

  always_comb begin
    inReady     = 1'b0;
    pixValid    = 1'b0;
    bypassValid = 1'b0;
    if (frameStart) begin
      inReady = 1'b0;
    end else if (!direct) begin
      bypassValid = inValid;
      inReady     = bypassReady;
    end else if (phase == PH_HOLD) begin
      pixValid = 1'b1;
    end else begin
      pixValid = inValid;
      inReady  = pixReady;
    end
  end

  always_comb begin
    phaseNext = phase;
    if (frameStart) begin
      phaseNext = PH_W0;
    end else if (direct) begin
      if (phase == PH_HOLD) begin
        if (pixReady) phaseNext = PH_W0;
      end else if (accept) begin
        if (rawFormat) begin
          phaseNext = PH_W0;
        end else begin
          unique case (phase)
            PH_W0:   phaseNext = PH_W1;
            PH_W1:   phaseNext = PH_W2;
            default: phaseNext = PH_HOLD;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_W0;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctl.sel      = phase;
    ctl.unpacked = rawFormat;
    ctl.capture  = direct && accept && !rawFormat && !frameStart;
  end

  // R9
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> phase == PH_W0);
  // R6
  group_end_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_W2 && accept && direct && !rawFormat && !frameStart) |=> phase == PH_HOLD);
  // R7
  sparse_no_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_W0 && accept && direct && rawFormat) |=> phase == PH_W0);
endmodule

// File: rtl/pix24_unpacker.sv
module pix24_unpacker
  import pix24_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                tftEnable,
  input  logic                deep24Enable,
  input  logic                rawFormat,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   inData,
  output logic                inReady,
  output logic                pixValid,
  output logic [PIX_W-1:0]    pixData,
  input  logic                pixReady,
  output logic                bypassValid,
  output logic [WORD_W-1:0]   bypassData,
  input  logic                bypassReady
);
  dpCtl_t ctl;

  pix24_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .tftEnable(tftEnable), .deep24Enable(deep24Enable), .rawFormat(rawFormat),
    .inValid(inValid), .pixReady(pixReady), .bypassReady(bypassReady),
    .inReady(inReady), .pixValid(pixValid), .bypassValid(bypassValid),
    .ctl(ctl)
  );

  pix24_datapath #(.WordW(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .pixData(pixData)
  );

  assign bypassData = inData;

  // R1
  no_pixel_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tftEnable && deep24Enable) |-> !pixValid);
  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(tftEnable && deep24Enable) && !frameStart) |->
      (bypassValid == inValid && inReady == bypassReady));
  // R9
  frame_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!inReady && !pixValid && !bypassValid));
  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady && !inReady && tftEnable && deep24Enable)
      ##1 (!frameStart && tftEnable && deep24Enable) |-> (pixValid && $stable(pixData)));
endmodule

// File: tb/pix24_unpacker_tb.sv
`timescale 1ns/1ps
module pix24_unpacker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        tftEnable = 1'b0;
  logic        deep24Enable = 1'b0;
  logic        rawFormat = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        pixValid;
  logic [23:0] pixData;
  logic        pixReady = 1'b0;
  logic        bypassValid;
  logic [31:0] bypassData;
  logic        bypassReady = 1'b0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pix24_unpacker u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .tftEnable(tftEnable), .deep24Enable(deep24Enable), .rawFormat(rawFormat),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .bypassValid(bypassValid), .bypassData(bypassData), .bypassReady(bypassReady)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [95:0] packGroup(input logic [23:0] p0, p1, p2, p3);
    logic [31:0] w0, w1, w2;
    w0 = {p1[7:0], p0};
    w1 = {p2[15:0], p1[23:8]};
    w2 = {p3, p2[23:16]};
    return {w2, w1, w0};
  endfunction

  // present a word with sink ready, check the emitted pixel, let it be taken
  task automatic pushWord(input logic [31:0] w, input logic [23:0] exp, input string req);
    @(negedge clk);
    inValid = 1'b1; inData = w; pixReady = 1'b1;
    #1;
    checkEq(req, "pixValid", pixValid, 1);
    checkEq(req, "pixData", pixData, exp);
    checkEq(req, "inReady", inReady, 1);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic takeHeld(input logic [23:0] exp, input string req);
    @(negedge clk);
    pixReady = 1'b1;
    #1;
    checkEq(req, "heldValid", pixValid, 1);
    checkEq(req, "heldReady", inReady, 0);
    checkEq(req, "heldData", pixData, exp);
    @(posedge clk); #1;
  endtask

  task automatic sendGroup(input logic [23:0] p0, p1, p2, p3);
    logic [95:0] g;
    g = packGroup(p0, p1, p2, p3);
    pushWord(g[31:0], p0, "R3");
    pushWord(g[63:32], p1, "R4");
    pushWord(g[95:64], p2, "R5");
    takeHeld(p3, "R6");
  endtask

  task automatic testReset;
    @(negedge clk);
    inValid = 1'b1; inData = 32'hA1B2C3D4; bypassReady = 1'b1;
    #1;
    checkEq("R10", "pixValid", pixValid, 0);
    checkEq("R10", "bypassValid", bypassValid, 1);
    @(negedge clk);
    inValid = 1'b0; tftEnable = 1'b1; deep24Enable = 1'b1; rawFormat = 1'b0;
    pushWord(32'h99123456, 24'h123456, "R10");
    // finish the group started above
    pushWord(32'h00007799, 24'h779999, "R4");
    pushWord(32'h44332211, 24'h110000, "R5");
    takeHeld(24'h443322, "R6");
  endtask

  task automatic testBypass;
    @(negedge clk);
    tftEnable = 1'b1; deep24Enable = 1'b0;
    inValid = 1'b1; inData = 32'hDEADBEEF; bypassReady = 1'b0; pixReady = 1'b1;
    #1;
    checkEq("R2", "bypassValid", bypassValid, 1);
    checkEq("R2", "bypassData", bypassData, 32'hDEADBEEF);
    checkEq("R2", "inReadyLow", inReady, 0);
    checkEq("R1", "pixValid", pixValid, 0);
    @(negedge clk);
    tftEnable = 1'b0; deep24Enable = 1'b1; bypassReady = 1'b1; inData = 32'h01020304;
    #1;
    checkEq("R2", "inReadyHigh", inReady, 1);
    checkEq("R2", "bypassData2", bypassData, 32'h01020304);
    checkEq("R1", "pixValid2", pixValid, 0);
    @(negedge clk);
    inValid = 1'b0; tftEnable = 1'b1; deep24Enable = 1'b1; bypassReady = 1'b0;
    #1;
    checkEq("R2", "bypassOffInDirect", bypassValid, 0);
  endtask

  task automatic testPacked;
    sendGroup(24'hABCDEF, 24'h123456, 24'hFEDCBA, 24'h0F1E2D);
    sendGroup(24'h000001, 24'hFFFFFF, 24'h800000, 24'h7FFFFF);
  endtask

  task automatic testBackpressure;
    logic [95:0] g;
    g = packGroup(24'h111111, 24'h222222, 24'h333333, 24'h444444);
    // stall on first word
    @(negedge clk);
    inValid = 1'b1; inData = g[31:0]; pixReady = 1'b0;
    #1;
    checkEq("R8", "stallReady", inReady, 0);
    checkEq("R8", "stallData", pixData, 24'h111111);
    @(posedge clk); #1;
    inValid = 1'b0;
    pushWord(g[31:0], 24'h111111, "R8");
    pushWord(g[63:32], 24'h222222, "R4");
    pushWord(g[95:64], 24'h333333, "R5");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      pixReady = 1'b0; inValid = 1'b1; inData = 32'hCAFEF00D;
      #1;
      checkEq("R8", "heldValid", pixValid, 1);
      checkEq("R8", "heldData", pixData, 24'h444444);
      checkEq("R8", "noAccept", inReady, 0);
    end
    @(negedge clk);
    inValid = 1'b0;
    takeHeld(24'h444444, "R6");
    pushWord(32'h00ABCDEF, 24'hABCDEF, "R6");
    // restore group start
    pushWord(32'h0, 24'h000000, "R4");
    pushWord(32'h0, 24'h000000, "R5");
    takeHeld(24'h000000, "R6");
  endtask

  task automatic testUnpacked;
    @(negedge clk);
    rawFormat = 1'b1;
    pushWord(32'hFF112233, 24'h112233, "R7");
    pushWord(32'h5A445566, 24'h445566, "R7");
    pushWord(32'h00778899, 24'h778899, "R7");
    pushWord(32'hC3ABCDEF, 24'hABCDEF, "R7");
    pushWord(32'h7E010203, 24'h010203, "R7");
    @(negedge clk);
    rawFormat = 1'b0;
  endtask

  task automatic testFrameStart;
    pushWord(32'hAA665544, 24'h665544, "R3");
    pushWord(32'hBBCCDDEE, 24'hDDEEAA, "R4");
    @(negedge clk);
    frameStart = 1'b1; inValid = 1'b1; inData = 32'h12345678; pixReady = 1'b1; bypassReady = 1'b1;
    #1;
    checkEq("R9", "inReady", inReady, 0);
    checkEq("R9", "pixValid", pixValid, 0);
    checkEq("R9", "bypassValid", bypassValid, 0);
    @(posedge clk); #1;
    frameStart = 1'b0; inValid = 1'b0;
    pushWord(32'h0F987654, 24'h987654, "R9");
    pushWord(32'h00003210, 24'h32100F, "R9");
    pushWord(32'h00000000, 24'h000000, "R5");
    takeHeld(24'h000000, "R6");
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testBypass();
    testPacked();
    testBackpressure();
    testUnpacked();
    testFrameStart();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule